// File: doc/BRIEF.md
# Lane-Mask-Aware Register Scoreboard

This block records which destination registers still have a write in flight for a SIMT core that may issue several warps, or disjoint lane subsets of one warp, in the same cycle. The issue logic asks it whether a candidate instruction touches a register that is still pending. It reports a reservation when an instruction issues and a release when a result is written back.

A mode input selects one of two tracking schemes. In warp mode, each warp has one pending bit per register in a primary table. A second table of the same shape serves instructions issued from a split of a warp that is already in flight, and a clear command can empty that table for a single warp. In lane mode, a single table of entries is used instead, with each entry holding a warp, a register and a lane mask. Two writes to one register from non-overlapping lanes of one warp are then stored side by side, and a hazard needs a real lane overlap.

The hazard result is combinational and reflects the state held at the start of the cycle. Clear, release and reserve all take effect at the next clock edge, applied in that order, so an entry released in a cycle can be given to a reserve in the same cycle.

Top module: `mask_scoreboard`

## Requirements
- R1: `mode_i`=0 selects warp mode and `mode_i`=1 selects lane mode. Reserve, check and release act only on the tables of the selected mode, so state recorded in one mode is not visible to checks in the other mode, and it stays intact while the other mode is in use.
- R2: In warp mode with the intra flag 0, a reserve marks each non-zero destination register of that warp as pending in the primary table. `chk_hit_o` is 1 when any non-zero source or destination register named by the check is pending for the checked warp, whatever the lane masks are.
- R3: In warp mode, a reserve of a register that is already pending in the table it targets drives `rsv_dup_o` to 1 in the same cycle. A release of that register in the same cycle is counted first. `rsv_dup_o` is 0 whenever `rsv_valid_i` is 0 or the block is in lane mode.
- R4: In warp mode, a reserve, check or release with the intra flag set to 1 uses only the secondary table, and one with the flag set to 0 uses only the primary table.
- R5: A clear of warp W empties every secondary-table register of W from the next cycle on. Other warps and the primary table are not changed.
- R6: Register number 0 means "no register". It is never reserved, never causes a hit, and a release of register 0 changes nothing.
- R7: In lane mode, an entry is identified by its (warp, register, lane mask) triple. Reserves with different masks on one register create separate entries and raise no error flag. A reserve of a triple that is already stored adds no second entry.
- R8: In lane mode, `chk_hit_o` is 1 only when a stored entry matches the checked warp and one of its non-zero registers, and the entry's mask shares at least one set bit with `chk_mask_i`.
- R9: A lane-mode release removes only the entry with exactly the given triple. Entries on the same register with other masks remain. A release that matches no entry, in either mode, changes nothing.
- R10: The lane table holds `ENTRIES` entries. If a reserve finds no free entry for a destination, `rsv_ovf_o` is 1 in that cycle and that destination is not stored. `rsv_ovf_o` is always 0 in warp mode.
- R11: A release and a reserve presented in the same cycle are applied release first, so the freed entry or bit can be reused at once. A check returns the state from before this cycle's updates, and those updates are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = warp mode, 1 = lane mode |
| rsv_valid_i | input | 1 | Reserve request |
| rsv_warp_i | input | $clog2(NUM_WARPS) | Warp of the reserve |
| rsv_dst_i | input | NDST*REG_W | Destination registers; slot d is bits [d*REG_W +: REG_W] |
| rsv_mask_i | input | LANES | Lane mask of the reserve (lane mode) |
| rsv_intra_i | input | 1 | Reserve targets the secondary table (warp mode) |
| rsv_dup_o | output | 1 | Reserve hit an already pending register (warp mode) |
| rsv_ovf_o | output | 1 | Reserve found no free entry (lane mode) |
| chk_warp_i | input | $clog2(NUM_WARPS) | Warp of the hazard check |
| chk_src_i | input | NSRC*REG_W | Source registers of the candidate |
| chk_dst_i | input | NDST*REG_W | Destination registers of the candidate |
| chk_mask_i | input | LANES | Lane mask of the candidate (lane mode) |
| chk_intra_i | input | 1 | Check against the secondary table (warp mode) |
| chk_hit_o | output | 1 | Hazard found |
| rel_valid_i | input | 1 | Release request |
| rel_warp_i | input | $clog2(NUM_WARPS) | Warp of the release |
| rel_reg_i | input | REG_W | Register being released |
| rel_mask_i | input | LANES | Lane mask of the release (lane mode) |
| rel_intra_i | input | 1 | Release from the secondary table (warp mode) |
| clr_valid_i | input | 1 | Clear the secondary table of one warp |
| clr_warp_i | input | $clog2(NUM_WARPS) | Warp to clear |

## Verification
The bench builds the block with 4 warps, 3-bit register numbers, 4 lanes, a 4-entry lane table and 2 source and 2 destination slots. At this size it can check every warp and register pair of the warp-mode tables against every other pair. It can also cross each of the 15 non-empty reserve masks with all 16 check masks. With only four entries, two dual-destination reserves fill the lane table, so overflow and the release-first reuse of an entry are easy to reach.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic {
        SB_MODE_WARP = 1'b0,
        SB_MODE_LANE = 1'b1
    } sb_mode_e;

    typedef enum int {
        SB_TBL_PRI = 0,
        SB_TBL_SEC = 1
    } sb_tbl_e;
endpackage

// File: rtl/sb_warp_table.sv
module sb_warp_table #(
    parameter int NUM_WARPS = 8,
    parameter int REG_W     = 6,
    parameter int NDST      = 2,
    parameter int NCHK      = 5
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         clr_i,
    input  logic [$clog2(NUM_WARPS)-1:0] clr_warp_i,
    input  logic                         rel_i,
    input  logic [$clog2(NUM_WARPS)-1:0] rel_warp_i,
    input  logic [REG_W-1:0]             rel_reg_i,
    input  logic                         rsv_i,
    input  logic [$clog2(NUM_WARPS)-1:0] rsv_warp_i,
    input  logic [NDST*REG_W-1:0]        rsv_dst_i,
    input  logic [$clog2(NUM_WARPS)-1:0] chk_warp_i,
    input  logic [NCHK*REG_W-1:0]        chk_regs_i,
    output logic                         hit_o,
    output logic                         dup_o
);
    localparam int NR    = 1 << REG_W;
    localparam int NBITS = NUM_WARPS * NR;

    logic [NBITS-1:0] busy_q, busy_d;

    // clear, then release, then reserve
    always_comb begin : p_next
        logic [REG_W-1:0] rr;
        busy_d = busy_q;
        dup_o  = 1'b0;
        rr     = '0;
        if (clr_i)
            busy_d[int'(clr_warp_i)*NR +: NR] = '0;
        if (rel_i && rel_reg_i != '0)
            busy_d[int'(rel_warp_i)*NR + int'(rel_reg_i)] = 1'b0;
        if (rsv_i) begin
            for (int d = 0; d < NDST; d++) begin
                rr = rsv_dst_i[d*REG_W +: REG_W];
                if (rr != '0) begin
                    dup_o = dup_o | busy_d[int'(rsv_warp_i)*NR + int'(rr)];
                    busy_d[int'(rsv_warp_i)*NR + int'(rr)] = 1'b1;
                end
            end
        end
    end

    always_comb begin : p_hit
        logic [REG_W-1:0] cr;
        hit_o = 1'b0;
        cr    = '0;
        for (int k = 0; k < NCHK; k++) begin
            cr = chk_regs_i[k*REG_W +: REG_W];
            if (cr != '0 && busy_q[int'(chk_warp_i)*NR + int'(cr)])
                hit_o = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) busy_q <= '0;
        else         busy_q <= busy_d;
    end
endmodule

// File: rtl/sb_lane_table.sv
module sb_lane_table #(
    parameter int NUM_WARPS = 8,
    parameter int REG_W     = 6,
    parameter int LANES     = 32,
    parameter int ENTRIES   = 16,
    parameter int NDST      = 2,
    parameter int NCHK      = 5
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         rel_i,
    input  logic [$clog2(NUM_WARPS)-1:0] rel_warp_i,
    input  logic [REG_W-1:0]             rel_reg_i,
    input  logic [LANES-1:0]             rel_mask_i,
    input  logic                         rsv_i,
    input  logic [$clog2(NUM_WARPS)-1:0] rsv_warp_i,
    input  logic [NDST*REG_W-1:0]        rsv_dst_i,
    input  logic [LANES-1:0]             rsv_mask_i,
    input  logic [$clog2(NUM_WARPS)-1:0] chk_warp_i,
    input  logic [NCHK*REG_W-1:0]        chk_regs_i,
    input  logic [LANES-1:0]             chk_mask_i,
    output logic                         hit_o,
    output logic                         ovf_o
);
    localparam int WW = $clog2(NUM_WARPS);

    logic [ENTRIES-1:0] vld_q, vld_d;
    logic [WW-1:0]      wid_q [ENTRIES];
    logic [WW-1:0]      wid_d [ENTRIES];
    logic [REG_W-1:0]   reg_q [ENTRIES];
    logic [REG_W-1:0]   reg_d [ENTRIES];
    logic [LANES-1:0]   msk_q [ENTRIES];
    logic [LANES-1:0]   msk_d [ENTRIES];

    // release first, then allocate lowest free entry per destination
    always_comb begin : p_next
        logic             need;
        logic             placed;
        logic [REG_W-1:0] rr;
        vld_d  = vld_q;
        wid_d  = wid_q;
        reg_d  = reg_q;
        msk_d  = msk_q;
        ovf_o  = 1'b0;
        need   = 1'b0;
        placed = 1'b0;
        rr     = '0;
        if (rel_i && rel_reg_i != '0) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (vld_q[e] && wid_q[e] == rel_warp_i && reg_q[e] == rel_reg_i
                    && msk_q[e] == rel_mask_i)
                    vld_d[e] = 1'b0;
            end
        end
        for (int d = 0; d < NDST; d++) begin
            rr   = rsv_dst_i[d*REG_W +: REG_W];
            need = rsv_i && (rr != '0);
            for (int e = 0; e < ENTRIES; e++) begin
                if (vld_d[e] && wid_d[e] == rsv_warp_i && reg_d[e] == rr
                    && msk_d[e] == rsv_mask_i)
                    need = 1'b0;
            end
            placed = 1'b0;
            for (int e = 0; e < ENTRIES; e++) begin
                if (need && !placed && !vld_d[e]) begin
                    vld_d[e] = 1'b1;
                    wid_d[e] = rsv_warp_i;
                    reg_d[e] = rr;
                    msk_d[e] = rsv_mask_i;
                    placed   = 1'b1;
                end
            end
            if (need && !placed)
                ovf_o = 1'b1;
        end
    end

    always_comb begin : p_hit
        logic [REG_W-1:0] cr;
        hit_o = 1'b0;
        cr    = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            for (int k = 0; k < NCHK; k++) begin
                cr = chk_regs_i[k*REG_W +: REG_W];
                if (vld_q[e] && wid_q[e] == chk_warp_i && cr != '0
                    && reg_q[e] == cr && |(msk_q[e] & chk_mask_i))
                    hit_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) vld_q <= '0;
        else         vld_q <= vld_d;
    end

    always_ff @(posedge clk_i) begin
        wid_q <= wid_d;
        reg_q <= reg_d;
        msk_q <= msk_d;
    end
endmodule

// File: rtl/mask_scoreboard.sv
module mask_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int REG_W     = 6,
    parameter int LANES     = 32,
    parameter int ENTRIES   = 16,
    parameter int NDST      = 2,
    parameter int NSRC      = 3
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         mode_i,
    input  logic                         rsv_valid_i,
    input  logic [$clog2(NUM_WARPS)-1:0] rsv_warp_i,
    input  logic [NDST*REG_W-1:0]        rsv_dst_i,
    input  logic [LANES-1:0]             rsv_mask_i,
    input  logic                         rsv_intra_i,
    output logic                         rsv_dup_o,
    output logic                         rsv_ovf_o,
    input  logic [$clog2(NUM_WARPS)-1:0] chk_warp_i,
    input  logic [NSRC*REG_W-1:0]        chk_src_i,
    input  logic [NDST*REG_W-1:0]        chk_dst_i,
    input  logic [LANES-1:0]             chk_mask_i,
    input  logic                         chk_intra_i,
    output logic                         chk_hit_o,
    input  logic                         rel_valid_i,
    input  logic [$clog2(NUM_WARPS)-1:0] rel_warp_i,
    input  logic [REG_W-1:0]             rel_reg_i,
    input  logic [LANES-1:0]             rel_mask_i,
    input  logic                         rel_intra_i,
    input  logic                         clr_valid_i,
    input  logic [$clog2(NUM_WARPS)-1:0] clr_warp_i
);
    localparam int NCHK = NSRC + NDST;

    sb_mode_e                mode;
    logic                    lane_on;
    logic [NCHK*REG_W-1:0]   chk_regs;
    logic [1:0]              tbl_hit;
    logic [1:0]              tbl_dup;
    logic                    lane_hit;
    logic                    lane_ovf;

    assign mode     = sb_mode_e'(mode_i);
    assign lane_on  = (mode == SB_MODE_LANE);
    assign chk_regs = {chk_dst_i, chk_src_i};

    for (genvar g = 0; g < 2; g++) begin : g_tbl
        localparam logic IS_SEC = (g == int'(SB_TBL_SEC));
        logic own_rsv, own_rel, own_clr;
        assign own_rsv = rsv_valid_i && !lane_on && (rsv_intra_i == IS_SEC);
        assign own_rel = rel_valid_i && !lane_on && (rel_intra_i == IS_SEC);
        assign own_clr = IS_SEC ? clr_valid_i : 1'b0;

        sb_warp_table #(
            .NUM_WARPS (NUM_WARPS),
            .REG_W     (REG_W),
            .NDST      (NDST),
            .NCHK      (NCHK)
        ) u_tbl (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .clr_i      (own_clr),
            .clr_warp_i (clr_warp_i),
            .rel_i      (own_rel),
            .rel_warp_i (rel_warp_i),
            .rel_reg_i  (rel_reg_i),
            .rsv_i      (own_rsv),
            .rsv_warp_i (rsv_warp_i),
            .rsv_dst_i  (rsv_dst_i),
            .chk_warp_i (chk_warp_i),
            .chk_regs_i (chk_regs),
            .hit_o      (tbl_hit[g]),
            .dup_o      (tbl_dup[g])
        );
    end

    sb_lane_table #(
        .NUM_WARPS (NUM_WARPS),
        .REG_W     (REG_W),
        .LANES     (LANES),
        .ENTRIES   (ENTRIES),
        .NDST      (NDST),
        .NCHK      (NCHK)
    ) u_lane (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rel_i      (rel_valid_i && lane_on),
        .rel_warp_i (rel_warp_i),
        .rel_reg_i  (rel_reg_i),
        .rel_mask_i (rel_mask_i),
        .rsv_i      (rsv_valid_i && lane_on),
        .rsv_warp_i (rsv_warp_i),
        .rsv_dst_i  (rsv_dst_i),
        .rsv_mask_i (rsv_mask_i),
        .chk_warp_i (chk_warp_i),
        .chk_regs_i (chk_regs),
        .chk_mask_i (chk_mask_i),
        .hit_o      (lane_hit),
        .ovf_o      (lane_ovf)
    );

    always_comb begin
        unique case (mode)
            SB_MODE_LANE: begin
                chk_hit_o = lane_hit;
                rsv_dup_o = 1'b0;
                rsv_ovf_o = lane_ovf;
            end
            default: begin
                chk_hit_o = tbl_hit[chk_intra_i];
                rsv_dup_o = |tbl_dup;
                rsv_ovf_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NUM_WARPS = 8,
    parameter int REG_W     = 6,
    parameter int LANES     = 32,
    parameter int NDST      = 2,
    parameter int NSRC      = 3
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         mode_i,
    input logic                         rsv_valid_i,
    input logic                         rsv_dup_o,
    input logic                         rsv_ovf_o,
    input logic [$clog2(NUM_WARPS)-1:0] chk_warp_i,
    input logic [NSRC*REG_W-1:0]        chk_src_i,
    input logic [NDST*REG_W-1:0]        chk_dst_i,
    input logic [LANES-1:0]             chk_mask_i,
    input logic                         chk_intra_i,
    input logic                         chk_hit_o,
    input logic                         clr_valid_i,
    input logic [$clog2(NUM_WARPS)-1:0] clr_warp_i
);
    assert_empty_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i && chk_mask_i == '0) |-> !chk_hit_o);

    assert_zero_regs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chk_src_i == '0 && chk_dst_i == '0) |-> !chk_hit_o);

    assert_no_ovf_warp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mode_i |-> !rsv_ovf_o);

    assert_no_dup_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i |-> !rsv_dup_o);

    assert_quiet_flags_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rsv_valid_i |-> (!rsv_dup_o && !rsv_ovf_o));

    assert_clear_empties_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_valid_i && !rsv_valid_i && !mode_i) |=>
        (!(!mode_i && chk_intra_i && chk_warp_i == $past(clr_warp_i)) || !chk_hit_o));
endmodule

bind mask_scoreboard sb_checker #(
    .NUM_WARPS (NUM_WARPS),
    .REG_W     (REG_W),
    .LANES     (LANES),
    .NDST      (NDST),
    .NSRC      (NSRC)
) u_chk (.*);

// File: tb/sim_mask_scoreboard.sv
`timescale 1ns/1ps
module sim_mask_scoreboard;
    localparam int NW = 4;
    localparam int RW = 3;
    localparam int LN = 4;
    localparam int NE = 4;
    localparam int ND = 2;
    localparam int NS = 2;
    localparam int WW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode = 1'b0;
    logic rsv_valid = 1'b0, rsv_intra = 1'b0;
    logic [WW-1:0] rsv_warp = '0;
    logic [ND*RW-1:0] rsv_dst = '0;
    logic [LN-1:0] rsv_mask = '0;
    logic rsv_dup, rsv_ovf;
    logic [WW-1:0] chk_warp = '0;
    logic [NS*RW-1:0] chk_src = '0;
    logic [ND*RW-1:0] chk_dst = '0;
    logic [LN-1:0] chk_mask = '0;
    logic chk_intra = 1'b0;
    logic chk_hit;
    logic rel_valid = 1'b0, rel_intra = 1'b0;
    logic [WW-1:0] rel_warp = '0;
    logic [RW-1:0] rel_reg = '0;
    logic [LN-1:0] rel_mask = '0;
    logic clr_valid = 1'b0;
    logic [WW-1:0] clr_warp = '0;

    int tests = 0;
    int fails = 0;
    logic last_dup, last_ovf;

    always #4 clk = ~clk;

    mask_scoreboard #(
        .NUM_WARPS(NW), .REG_W(RW), .LANES(LN), .ENTRIES(NE), .NDST(ND), .NSRC(NS)
    ) u0 (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
        .rsv_valid_i(rsv_valid), .rsv_warp_i(rsv_warp), .rsv_dst_i(rsv_dst),
        .rsv_mask_i(rsv_mask), .rsv_intra_i(rsv_intra),
        .rsv_dup_o(rsv_dup), .rsv_ovf_o(rsv_ovf),
        .chk_warp_i(chk_warp), .chk_src_i(chk_src), .chk_dst_i(chk_dst),
        .chk_mask_i(chk_mask), .chk_intra_i(chk_intra), .chk_hit_o(chk_hit),
        .rel_valid_i(rel_valid), .rel_warp_i(rel_warp), .rel_reg_i(rel_reg),
        .rel_mask_i(rel_mask), .rel_intra_i(rel_intra),
        .clr_valid_i(clr_valid), .clr_warp_i(clr_warp)
    );

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic idle();
        rsv_valid = 1'b0;
        rel_valid = 1'b0;
        clr_valid = 1'b0;
    endtask

    task automatic begin_op();
        @(negedge clk);
    endtask

    task automatic set_rsv(input int w, input int d0, input int d1, input int m, input int intra);
        rsv_valid = 1'b1;
        rsv_warp  = WW'(w);
        rsv_dst   = {RW'(d1), RW'(d0)};
        rsv_mask  = LN'(m);
        rsv_intra = intra[0];
    endtask

    task automatic set_rel(input int w, input int r, input int m, input int intra);
        rel_valid = 1'b1;
        rel_warp  = WW'(w);
        rel_reg   = RW'(r);
        rel_mask  = LN'(m);
        rel_intra = intra[0];
    endtask

    task automatic commit();
        #1;
        last_dup = rsv_dup;
        last_ovf = rsv_ovf;
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_rsv(input int w, input int d0, input int d1, input int m, input int intra);
        begin_op();
        set_rsv(w, d0, d1, m, intra);
        commit();
    endtask

    task automatic do_rel(input int w, input int r, input int m, input int intra);
        begin_op();
        set_rel(w, r, m, intra);
        commit();
    endtask

    task automatic do_clr(input int w);
        begin_op();
        clr_valid = 1'b1;
        clr_warp  = WW'(w);
        commit();
    endtask

    task automatic set_mode(input logic m);
        begin_op();
        mode = m;
    endtask

    task automatic chk(input int w, input int s0, input int d0, input int m, input int intra,
                       input logic exp, input string tag);
        chk_warp  = WW'(w);
        chk_src   = {RW'(0), RW'(s0)};
        chk_dst   = {RW'(0), RW'(d0)};
        chk_mask  = LN'(m);
        chk_intra = intra[0];
        #1;
        expect_bit(chk_hit, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        expect_bit(rsv_dup, 1'b0, "reset dup R3");
        expect_bit(rsv_ovf, 1'b0, "reset ovf R10");
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < 8; r++) begin
                chk(w, r, 0, 15, 0, 1'b0, "reset primary R2");
                chk(w, r, 0, 15, 1, 1'b0, "reset secondary R4");
            end

        // R2: warp-mode primary sweep over every warp/register
        for (int w = 0; w < NW; w++)
            for (int r = 1; r < 8; r++) begin
                do_rsv(w, r, 0, 0, 0);
                expect_bit(last_dup, 1'b0, "fresh reserve no dup R3");
                for (int w2 = 0; w2 < NW; w2++)
                    for (int r2 = 0; r2 < 8; r2++)
                        chk(w2, r2, 0, (w2 * 3) & 15, 0, (w2 == w) && (r2 == r), "primary sweep R2");
                chk(w, 0, r, 0, 0, 1'b1, "dest slot hit R2");
                do_rel(w, r, 0, 0);
                chk(w, r, 0, 15, 0, 1'b0, "release primary R9");
            end

        // R3: duplicate reserve
        do_rsv(0, 2, 0, 0, 0);
        do_rsv(0, 2, 0, 0, 0);
        expect_bit(last_dup, 1'b1, "duplicate reserve R3");
        do_rsv(1, 2, 0, 0, 0);
        expect_bit(last_dup, 1'b0, "other warp no dup R3");
        begin_op();
        set_rel(0, 2, 0, 0);
        set_rsv(0, 2, 0, 0, 0);
        commit();
        expect_bit(last_dup, 1'b0, "release first no dup R11");
        chk(0, 2, 0, 0, 0, 1'b1, "re-reserved after release R11");
        do_rel(0, 2, 0, 0);
        do_rel(1, 2, 0, 0);

        // R4: secondary table isolation
        do_rsv(2, 5, 0, 0, 1);
        chk(2, 5, 0, 0, 0, 1'b0, "intra not in primary R4");
        chk(2, 5, 0, 0, 1, 1'b1, "intra in secondary R4");
        do_rsv(2, 5, 0, 0, 0);
        expect_bit(last_dup, 1'b0, "separate tables no dup R4");
        do_rel(2, 5, 0, 1);
        chk(2, 5, 0, 0, 0, 1'b1, "primary kept R4");
        chk(2, 5, 0, 0, 1, 1'b0, "secondary released R4");
        do_rel(2, 5, 0, 0);
        chk(2, 5, 0, 0, 0, 1'b0, "primary released R4");

        // R5: clear
        do_rsv(1, 3, 6, 0, 1);
        do_rsv(2, 3, 0, 0, 1);
        do_rsv(1, 4, 0, 0, 0);
        do_clr(1);
        chk(1, 3, 0, 0, 1, 1'b0, "cleared warp R5");
        chk(1, 6, 0, 0, 1, 1'b0, "cleared warp second reg R5");
        chk(2, 3, 0, 0, 1, 1'b1, "other warp kept R5");
        chk(1, 4, 0, 0, 0, 1'b1, "primary kept on clear R5");
        do_clr(2);
        do_rel(1, 4, 0, 0);

        // R6: register 0
        do_rsv(3, 0, 0, 0, 0);
        expect_bit(last_dup, 1'b0, "reg0 reserve R6");
        chk(3, 0, 0, 15, 0, 1'b0, "reg0 no hit R6");
        do_rsv(3, 6, 0, 0, 0);
        do_rel(3, 0, 0, 0);
        chk(3, 6, 0, 0, 0, 1'b1, "reg0 release no effect R6");
        do_rel(3, 6, 0, 0);
        do_rel(3, 6, 0, 0);
        chk(3, 6, 0, 0, 0, 1'b0, "absent release harmless R9");

        // R1: mode isolation
        do_rsv(0, 1, 0, 0, 0);
        set_mode(1'b1);
        chk(0, 1, 0, 15, 0, 1'b0, "warp state hidden in lane mode R1");
        do_rsv(0, 1, 0, 3, 0);
        expect_bit(last_dup, 1'b0, "lane reserve no dup R1");
        set_mode(1'b0);
        chk(0, 1, 0, 0, 0, 1'b1, "warp state intact R1");
        do_rel(0, 1, 0, 0);
        chk(0, 1, 0, 15, 0, 1'b0, "warp release R1");
        set_mode(1'b1);
        chk(0, 1, 0, 15, 0, 1'b1, "lane state intact R1");
        do_rel(0, 1, 3, 0);
        chk(0, 1, 0, 15, 0, 1'b0, "lane release R1");
        chk(0, 1, 0, 15, 1, 1'b0, "intra flag ignored in lane mode R1");

        // R8: lane overlap sweep
        for (int m1 = 1; m1 < 16; m1++) begin
            do_rsv(1, 4, 0, m1, 0);
            expect_bit(last_ovf, 1'b0, "sweep reserve fits R10");
            for (int m2 = 0; m2 < 16; m2++)
                chk(1, 4, 0, m2, 0, (m1 & m2) != 0, "lane overlap R8");
            chk(1, 0, 4, 15, 0, 1'b1, "lane dest slot R8");
            chk(2, 4, 0, 15, 0, 1'b0, "lane other warp R8");
            chk(1, 5, 0, 15, 0, 1'b0, "lane other reg R8");
            do_rel(1, 4, m1, 0);
            chk(1, 4, 0, 15, 0, 1'b0, "lane released R9");
        end

        // R7/R9: disjoint masks coexist
        do_rsv(0, 3, 0, 3, 0);
        do_rsv(0, 3, 0, 12, 0);
        expect_bit(last_ovf, 1'b0, "disjoint no ovf R7");
        expect_bit(last_dup, 1'b0, "disjoint no dup R7");
        chk(0, 3, 0, 1, 0, 1'b1, "low lanes pending R7");
        chk(0, 3, 0, 4, 0, 1'b1, "high lanes pending R7");
        do_rel(0, 3, 3, 0);
        chk(0, 3, 0, 1, 0, 1'b0, "exact release low R9");
        chk(0, 3, 0, 4, 0, 1'b1, "other mask kept R9");
        do_rel(0, 3, 5, 0);
        chk(0, 3, 0, 4, 0, 1'b1, "non-matching mask release R9");
        do_rel(0, 3, 12, 0);
        chk(0, 3, 0, 15, 0, 1'b0, "all released R9");
        do_rsv(0, 6, 0, 2, 0);
        do_rsv(0, 6, 0, 2, 0);
        do_rel(0, 6, 2, 0);
        chk(0, 6, 0, 2, 0, 1'b0, "identical reserve single entry R7");

        // R10/R11: overflow and reuse
        do_rsv(0, 1, 2, 1, 0);
        expect_bit(last_ovf, 1'b0, "fill half R10");
        do_rsv(0, 3, 4, 1, 0);
        expect_bit(last_ovf, 1'b0, "fill full R10");
        do_rsv(0, 5, 0, 1, 0);
        expect_bit(last_ovf, 1'b1, "overflow R10");
        chk(0, 5, 0, 1, 0, 1'b0, "overflowed not stored R10");
        chk(0, 4, 0, 1, 0, 1'b1, "full table intact R10");
        begin_op();
        set_rel(0, 1, 1, 0);
        set_rsv(0, 5, 0, 1, 0);
        chk(0, 5, 0, 1, 0, 1'b0, "check before edge R11");
        commit();
        expect_bit(last_ovf, 1'b0, "freed entry reused R11");
        chk(0, 5, 0, 1, 0, 1'b1, "reused entry visible R11");
        chk(0, 1, 0, 1, 0, 1'b0, "released entry gone R11");
        do_rel(0, 2, 1, 0);
        do_rel(0, 3, 1, 0);
        do_rel(0, 4, 1, 0);
        do_rel(0, 5, 1, 0);
        for (int r = 1; r < 8; r++)
            chk(0, r, 0, 15, 0, 1'b0, "lane table drained R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule